// File: doc/BRIEF.md
# USB Host Bus-Command Control Register

This block is the host-side control register of a USB port, together with the small sequencer behind it. Software writes one word to request a bus reset or a bus resume, to turn frame generation on or off, and to choose how the host handles speed. The block turns each new request into a one-cycle command strobe for a line-signalling back end. It then waits for that back end to report completion, and it clears the command bit on its own when the report arrives. Hardware can also turn frame generation on: this happens when software requests a reset, or when the back end reports that a downstream device has signalled resume.

A frame timer runs while frame generation is enabled. Once per millisecond it emits a start-of-frame strobe, or a keep-alive strobe when the line is in low-speed mode. The period is a parameter given in clock cycles. No frame strobe is emitted while a reset or a resume is being signalled. The speed field is decoded into two flags. One allows the high-speed reset handshake. The other keeps the port at full speed.

Top module: `usbh_busctl`

## Requirements
- R1: After a synchronous reset the register reads all zeros, and every command strobe and frame strobe output is low.
- R2: The register sits at address `REG_OFFSET`. It holds frame enable in bit 8, reset in bit 9, resume in bit 10 and the speed field in bits 13:12. Every other bit reads zero. Writes to any other address change nothing, and reads of any other address return zero.
- R3: Writing 1 to bit 9 while no reset is active sets the bit and raises `be_reset_start` for exactly one cycle, both on the same edge. The bit clears on the edge where `be_reset_done` is sampled high.
- R4: A write with bit 9 at 0 while a reset is active clears the bit and raises `be_reset_abort` for one cycle. If `be_reset_done` is high in that same cycle, the bit clears with no abort strobe.
- R5: Writing 1 to bit 10 while no resume is active sets the bit and raises `be_resume_start` for one cycle. The bit clears when `be_resume_done` is sampled high. Writing 0 to bit 10 leaves it unchanged.
- R6: Any write with bit 9 at 1 clears the resume bit. If bits 9 and 10 are both written as 1, only the reset starts.
- R7: Bit 8 is forced to 1 by a reset request or by `be_upstream_resume`. This hardware set overrides a software write of 0 in the same cycle.
- R8: While bit 8 is 1, a frame strobe appears every `CYC_PER_MS` cycles. The first one comes `CYC_PER_MS-1` cycles after the edge that enabled frame generation. It appears on `frame_sof` when `line_ls_mode` is 0 and on `frame_keepalive` when it is 1, never on both.
- R9: No frame strobe is emitted while the reset bit or the resume bit is 1.
- R10: Speed field 00 drives `spd_hs_allowed` high. Field 11 drives `spd_force_fs` high. The reserved codes 01 and 10 drive both flags low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| line_ls_mode | input | 1 | Line runs at low speed; frame strobes become keep-alive |
| be_reset_done | input | 1 | Back end has finished sending the bus reset |
| be_resume_done | input | 1 | Back end has finished sending the bus resume |
| be_upstream_resume | input | 1 | Downstream device signalled resume |
| be_reset_start | output | 1 | One-cycle request to start a bus reset |
| be_reset_abort | output | 1 | One-cycle request to stop a bus reset in progress |
| be_resume_start | output | 1 | One-cycle request to start a bus resume |
| frame_sof | output | 1 | Start-of-frame strobe |
| frame_keepalive | output | 1 | Low-speed keep-alive strobe |
| spd_force_fs | output | 1 | Port is held at full speed |
| spd_hs_allowed | output | 1 | High-speed reset handshake is allowed |

## Verification
The hardest situations to reach are the ones where two causes arrive on the same edge. Examples are a reset completion that coincides with a software write of 0, an upstream resume that coincides with a write clearing frame enable, and a write that sets both reset and resume. The bench drives each of these by placing the back-end completion or event input in the very cycle of the register write. It then reads the word back and checks the strobes one cycle later. Frame suppression is checked by holding a reset open, with no completion, for several frame periods and counting strobes over that window.

// File: rtl/usbh_busctl_pkg.sv
package usbh_busctl_pkg;

    localparam int BIT_SOF    = 8;
    localparam int BIT_RST    = 9;
    localparam int BIT_RSM    = 10;
    localparam int BIT_SPD_LO = 12;
    localparam int DATA_W     = 32;

    typedef enum logic [1:0] {
        SPD_NORMAL    = 2'b00,
        SPD_RSV_A     = 2'b01,
        SPD_RSV_B     = 2'b10,
        SPD_FULL_ONLY = 2'b11
    } spd_mode_e;

    typedef struct packed {
        spd_mode_e spd;
        logic      resume;
        logic      reset;
        logic      sof_en;
    } ctl_t;

    typedef struct packed {
        logic [1:0] spd;
        logic       resume;
        logic       reset;
        logic       sof_en;
    } wr_fields_t;

    typedef struct packed {
        logic reset_start;
        logic reset_abort;
        logic resume_start;
    } cmd_evt_t;

    function automatic wr_fields_t decode_write(input logic [DATA_W-1:0] d);
        wr_fields_t f;
        f.spd    = d[BIT_SPD_LO +: 2];
        f.resume = d[BIT_RSM];
        f.reset  = d[BIT_RST];
        f.sof_en = d[BIT_SOF];
        return f;
    endfunction

    function automatic logic [DATA_W-1:0] pack_read(input ctl_t c);
        logic [DATA_W-1:0] w;
        w                  = '0;
        w[BIT_SPD_LO +: 2] = c.spd;
        w[BIT_RSM]         = c.resume;
        w[BIT_RST]         = c.reset;
        w[BIT_SOF]         = c.sof_en;
        return w;
    endfunction

endpackage

// File: rtl/usbh_busctl_regs.sv
module usbh_busctl_regs
    import usbh_busctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] wdata,
    input  logic              reset_done,
    input  logic              resume_done,
    input  logic              upstream_resume,
    output ctl_t              ctl_q,
    output cmd_evt_t          evt
);

    ctl_t       ctl_d;
    wr_fields_t req;
    logic       reset_req;

    always_comb begin
        req       = decode_write(wdata);
        ctl_d     = ctl_q;
        evt       = '0;
        reset_req = wr_hit && req.reset;

        if (wr_hit) begin
            ctl_d.spd    = spd_mode_e'(req.spd);
            ctl_d.sof_en = req.sof_en;
        end

        // reset command: completion beats abort, abort only from an active reset
        if (ctl_q.reset) begin
            if (reset_done) begin
                ctl_d.reset = 1'b0;
            end else if (wr_hit && !req.reset) begin
                ctl_d.reset     = 1'b0;
                evt.reset_abort = 1'b1;
            end
        end else if (reset_req) begin
            ctl_d.reset     = 1'b1;
            evt.reset_start = 1'b1;
        end

        // resume command: a reset request always wins
        if (reset_req) begin
            ctl_d.resume = 1'b0;
        end else if (ctl_q.resume) begin
            if (resume_done) ctl_d.resume = 1'b0;
        end else if (wr_hit && req.resume) begin
            ctl_d.resume     = 1'b1;
            evt.resume_start = 1'b1;
        end

        // hardware set of frame generation overrides the written value
        if (reset_req || upstream_resume) ctl_d.sof_en = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= '0;
        else     ctl_q <= ctl_d;
    end

endmodule

// File: rtl/usbh_busctl_strobe.sv
module usbh_busctl_strobe
    import usbh_busctl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  cmd_evt_t evt,
    output cmd_evt_t evt_q
);

    always_ff @(posedge clk) begin
        if (rst) evt_q <= '0;
        else     evt_q <= evt;
    end

endmodule

// File: rtl/usbh_busctl_frame.sv
module usbh_busctl_frame #(
    parameter int CYC_PER_MS = 60000
) (
    input  logic clk,
    input  logic rst,
    input  logic sof_en,
    input  logic busy,
    input  logic ls_mode,
    output logic sof_strobe,
    output logic ka_strobe
);

    localparam int          CW   = (CYC_PER_MS > 2) ? $clog2(CYC_PER_MS) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYC_PER_MS - 1);

    logic [CW-1:0] cnt;
    logic          tick;

    always_ff @(posedge clk) begin
        if (rst || !sof_en)  cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                 cnt <= cnt + 1'b1;
    end

    assign tick       = sof_en && (cnt == LAST) && !busy;
    assign sof_strobe = tick && !ls_mode;
    assign ka_strobe  = tick && ls_mode;

endmodule

// File: rtl/usbh_busctl.sv
module usbh_busctl
    import usbh_busctl_pkg::*;
#(
    parameter int              ADDR_W     = 12,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 12'h400,
    parameter int              CYC_PER_MS = 60000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              line_ls_mode,
    input  logic              be_reset_done,
    input  logic              be_resume_done,
    input  logic              be_upstream_resume,
    output logic              be_reset_start,
    output logic              be_reset_abort,
    output logic              be_resume_start,
    output logic              frame_sof,
    output logic              frame_keepalive,
    output logic              spd_force_fs,
    output logic              spd_hs_allowed
);

    logic     hit;
    ctl_t     ctl_q;
    cmd_evt_t evt, evt_q;
    logic     ctl_reset, ctl_resume, ctl_sof;

    assign hit = (bus_addr == REG_OFFSET);

    usbh_busctl_regs u_regs (
        .clk             (clk),
        .rst             (rst),
        .wr_hit          (bus_wr && hit),
        .wdata           (bus_wdata),
        .reset_done      (be_reset_done),
        .resume_done     (be_resume_done),
        .upstream_resume (be_upstream_resume),
        .ctl_q           (ctl_q),
        .evt             (evt)
    );

    usbh_busctl_strobe u_strobe (
        .clk   (clk),
        .rst   (rst),
        .evt   (evt),
        .evt_q (evt_q)
    );

    assign ctl_reset  = ctl_q.reset;
    assign ctl_resume = ctl_q.resume;
    assign ctl_sof    = ctl_q.sof_en;

    usbh_busctl_frame #(.CYC_PER_MS(CYC_PER_MS)) u_frame (
        .clk        (clk),
        .rst        (rst),
        .sof_en     (ctl_sof),
        .busy       (ctl_reset || ctl_resume),
        .ls_mode    (line_ls_mode),
        .sof_strobe (frame_sof),
        .ka_strobe  (frame_keepalive)
    );

    assign bus_rdata       = hit ? pack_read(ctl_q) : '0;
    assign be_reset_start  = evt_q.reset_start;
    assign be_reset_abort  = evt_q.reset_abort;
    assign be_resume_start = evt_q.resume_start;
    assign spd_force_fs    = (ctl_q.spd == SPD_FULL_ONLY);
    assign spd_hs_allowed  = (ctl_q.spd == SPD_NORMAL);

endmodule

// File: rtl/usbh_busctl_chk.sv
module usbh_busctl_chk (
    input logic clk,
    input logic rst,
    input logic reset_q,
    input logic resume_q,
    input logic sof_q,
    input logic reset_done,
    input logic upstream_resume,
    input logic reset_start,
    input logic reset_abort,
    input logic sof_strobe,
    input logic ka_strobe,
    input logic force_fs,
    input logic hs_ok
);

    a_r3_start_with_bit: assert property (@(posedge clk) disable iff (rst)
        $rose(reset_q) |-> reset_start);

    a_r3_done_clears: assert property (@(posedge clk) disable iff (rst)
        (reset_q && reset_done) |=> !reset_q);

    a_r4_abort_from_active: assert property (@(posedge clk) disable iff (rst)
        reset_abort |-> ($past(reset_q) && !reset_q));

    a_r6_reset_drops_resume: assert property (@(posedge clk) disable iff (rst)
        $rose(reset_q) |-> !resume_q);

    a_r7_upstream_sets_sof: assert property (@(posedge clk) disable iff (rst)
        upstream_resume |=> sof_q);

    a_r8_one_kind: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sof_strobe, ka_strobe}));

    a_r9_quiet_when_busy: assert property (@(posedge clk) disable iff (rst)
        (reset_q || resume_q) |-> !(sof_strobe || ka_strobe));

    a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(force_fs && hs_ok));

endmodule

bind usbh_busctl usbh_busctl_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .reset_q         (ctl_reset),
    .resume_q        (ctl_resume),
    .sof_q           (ctl_sof),
    .reset_done      (be_reset_done),
    .upstream_resume (be_upstream_resume),
    .reset_start     (be_reset_start),
    .reset_abort     (be_reset_abort),
    .sof_strobe      (frame_sof),
    .ka_strobe       (frame_keepalive),
    .force_fs        (spd_force_fs),
    .hs_ok           (spd_hs_allowed)
);

// File: tb/usbh_busctl_test.sv
module usbh_busctl_test;

    localparam int          CYC = 20;
    localparam logic [11:0] OFS = 12'h400;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = OFS;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ls = 1'b0, rdone = 1'b0, sdone = 1'b0, upres = 1'b0;
    logic        r_start, r_abort, s_start, sof, ka, ffs, hsok;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    usbh_busctl #(.CYC_PER_MS(CYC)) uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .line_ls_mode(ls),
        .be_reset_done(rdone), .be_resume_done(sdone), .be_upstream_resume(upres),
        .be_reset_start(r_start), .be_reset_abort(r_abort), .be_resume_start(s_start),
        .frame_sof(sof), .frame_keepalive(ka), .spd_force_fs(ffs), .spd_hs_allowed(hsok)
    );

    // {wr, reset_done, resume_done, upstream_resume, wdata[15:0], expected rdata[15:0]}
    localparam logic [35:0] VEC [12] = '{
        {4'b1000, 16'h3000, 16'h3000},
        {4'b1000, 16'h0000, 16'h0000},
        {4'b1000, 16'h0100, 16'h0100},
        {4'b1000, 16'h0500, 16'h0500},
        {4'b0010, 16'h0000, 16'h0100},
        {4'b1000, 16'h0200, 16'h0300},
        {4'b0100, 16'h0000, 16'h0100},
        {4'b1001, 16'h0000, 16'h0100},
        {4'b1000, 16'hFFFF, 16'h3300},
        {4'b1000, 16'h3300, 16'h3300},
        {4'b1000, 16'h0100, 16'h0100},
        {4'b1000, 16'h2000, 16'h2000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic w, input logic [31:0] wd, input logic rd,
                        input logic sd, input logic up);
        @(negedge clk);
        bus_wr = w; bus_wdata = wd; rdone = rd; sdone = sd; upres = up;
        @(posedge clk);
        #1;
        bus_wr = 1'b0; rdone = 1'b0; sdone = 1'b0; upres = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        int cnt_a, cnt_b, first;
        repeat (2) @(posedge clk);
        #1;
        // R1 reset state
        check("R1 rdata", bus_rdata, 32'h0);
        check("R1 strobes", {29'b0, r_start, r_abort, s_start}, 32'h0);
        check("R1 frame", {30'b0, sof, ka}, 32'h0);
        do_reset();
        check("R1 rdata after release", bus_rdata, 32'h0);

        // table walk: R2 R3 R5 R6 R7 R4
        foreach (VEC[i]) begin
            step(VEC[i][35], {16'h0, VEC[i][31:16]}, VEC[i][34], VEC[i][33], VEC[i][32]);
            check($sformatf("R2/R3/R5/R6/R7 vector %0d", i), bus_rdata, {16'h0, VEC[i][15:0]});
        end

        // R10 speed decode: current field is 10 (reserved)
        check("R10 reserved", {30'b0, ffs, hsok}, 32'h0);
        step(1, 32'h3000, 0, 0, 0);
        check("R10 full only", {30'b0, ffs, hsok}, 32'h2);
        step(1, 32'h0000, 0, 0, 0);
        check("R10 normal", {30'b0, ffs, hsok}, 32'h1);

        // R2 other address ignored
        bus_addr = 12'h404;
        step(1, 32'h0000_3700, 0, 0, 0);
        check("R2 other addr reads zero", bus_rdata, 32'h0);
        bus_addr = OFS; #1;
        check("R2 other addr write ignored", bus_rdata, 32'h0);

        // R3 start strobe width and completion
        do_reset();
        step(1, 32'h0200, 0, 0, 0);
        check("R3 start strobe", {31'b0, r_start}, 32'h1);
        @(posedge clk); #1;
        check("R3 start one cycle", {31'b0, r_start}, 32'h0);
        step(0, 0, 1, 0, 0);
        check("R3 cleared by done", bus_rdata, 32'h0100);
        check("R3 no abort on done", {31'b0, r_abort}, 32'h0);

        // R4 abort by write of zero
        step(1, 32'h0200, 0, 0, 0);
        step(1, 32'h0100, 0, 0, 0);
        check("R4 abort strobe", {31'b0, r_abort}, 32'h1);
        check("R4 bit cleared", bus_rdata, 32'h0100);
        // R4 completion and zero-write together
        step(1, 32'h0200, 0, 0, 0);
        step(1, 32'h0000, 1, 0, 0);
        check("R4 done wins no abort", {31'b0, r_abort}, 32'h0);
        check("R4 done wins rdata", bus_rdata, 32'h0);

        // R5 resume strobe and zero-write ignored
        step(1, 32'h0500, 0, 0, 0);
        check("R5 resume strobe", {31'b0, s_start}, 32'h1);
        step(1, 32'h0100, 0, 0, 0);
        check("R5 zero write ignored", bus_rdata, 32'h0500);
        // R6 reset request drops resume
        step(1, 32'h0200, 0, 0, 0);
        check("R6 resume dropped", bus_rdata, 32'h0300);
        check("R6 reset started", {31'b0, r_start}, 32'h1);
        step(0, 0, 1, 0, 0);

        // R8 frame timing
        do_reset();
        step(1, 32'h0100, 0, 0, 0);
        cnt_a = 0; first = -1;
        for (int i = 0; i < 2*CYC; i++) begin
            if (i > 0) begin @(posedge clk); #1; end
            if (sof) begin cnt_a++; if (first < 0) first = i; end
            if (ka) cnt_a += 100;
        end
        check("R8 first sof cycle", first, CYC-1);
        check("R8 sof count", cnt_a, 2);

        // R9 suppressed during reset
        step(1, 32'h0200, 0, 0, 0);
        cnt_a = 0;
        for (int i = 0; i < 3*CYC; i++) begin
            @(posedge clk); #1;
            if (sof || ka) cnt_a++;
        end
        check("R9 none during reset", cnt_a, 0);

        // R8 keep-alive in low speed
        ls = 1'b1;
        step(1, 32'h0100, 0, 0, 0);
        cnt_a = 0; cnt_b = 0;
        for (int i = 0; i < 2*CYC; i++) begin
            @(posedge clk); #1;
            if (ka) cnt_a++;
            if (sof) cnt_b++;
        end
        check("R8 keepalive count", cnt_a, 2);
        check("R8 no sof in low speed", cnt_b, 0);
        ls = 1'b0;

        finish_run();
    end

endmodule